// File: doc/BRIEF.md
# EEPROM Write Status Read Responder

This block is the read side of a byte-wide parallel EEPROM. It watches the three active-low bus strobes (chip select, output enable, write enable), decides when the host is making a read, and drives the data bus with the byte the host should see. When no internal write is in progress, a read returns the array byte that the storage supplies for the current address.

While a write is in progress, a read returns a status byte instead of stored data. The status byte has three flag bits:
- a polling bit, which is the complement of the top bit of the byte written last;
- a toggle bit, which starts at zero in each new phase and flips on every read;
- a timer flag, which goes high once the page load window has closed.

The remaining low bits read as zero. A host can watch any of these bits to learn when programming has finished.

The strobes come straight from the pins and pass through a synchroniser before they are decoded. The write controller provides these inputs, all synchronous to the clock:
- the busy flag;
- the page-load-timer-running flag;
- the byte written last.

The block drives a data word and a separate output-enable. A pad ring outside the block turns these into the tristate bus.

Top module: `ee_status_responder`

## Requirements
- R1: The output enable `dq_oe` is high only for a read, which is chip select low, output enable low and write enable high. At every other time `dq_oe` is 0 and `dq_out` is 0, and a non-read strobe combination does not advance the toggle bit.
- R2: A read while `busy` is 0 drives `dq_out` with `arr_rdata` unchanged.
- R3: A read while `busy` is 1 drives bit DW-1 (bit 7 by default) with the inverse of bit DW-1 of `last_data`, whatever the address.
- R4: Once `busy` returns to 0, a read of the byte written last shows its true value, including bit DW-1.
- R5: While `busy` is 1, bit DW-2 (bit 6) reads 0 on the first read after a phase starts and alternates on each later read.
- R6: A read advances the toggle only once, at its start, so bit DW-2 stays steady for as long as the strobes stay in the read state.
- R7: The toggle returns to 0 when a phase starts. A phase starts when `busy` rises, when `plt_run` rises, or when `plt_run` falls while `busy` stays high (the start of programming).
- R8: While `busy` is 1, bit DW-3 (bit 5) reads 0 while `plt_run` is 1 and reads 1 while `plt_run` is 0.
- R9: While `busy` is 1, bits DW-4 down to 0 read 0.
- R10: A strobe change reaches `dq_oe` and `dq_out` on the third rising clock edge after it is applied: two synchroniser stages, then the output register.
- R11: While reset is active, and until the first read after reset, `dq_oe` and `dq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| busy | input | 1 | Write controller: a load or programming phase is in progress |
| plt_run | input | 1 | Write controller: the page load timer is running |
| last_data | input | DW | Byte most recently written |
| arr_rdata | input | DW | Array byte at the current read address |
| dq_out | output | DW | Data to drive onto the bus |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The hardest situation to reach is a toggle sequence that crosses phase boundaries. It needs several reads inside one busy phase, non-read strobe activity between them, and then a move from loading to programming that must clear the toggle without the bus being idle. The stimulus walks the write-controller inputs at random through idle, loading and programming. Between steps it makes reads of random length and non-read strobe patterns. A bench model tracks the expected toggle value across all of it. Directed sequences add reads of the byte written last after busy clears, and two reads followed by the start of programming.

// File: rtl/ee_rsp_pkg.sv
package ee_rsp_pkg;
  // number of status flags at the top of the busy word
  localparam int STAT_W = 3;

  // flags ordered {poll, toggle, timer expired}, top bit first
  function automatic logic [STAT_W-1:0] status_flags(input logic last_msb,
                                                     input logic tog,
                                                     input logic plt_run);
    return {~last_msb, tog, ~plt_run};
  endfunction
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rst_sn,
  output logic rd_act,
  output logic rd_start
);
  localparam int NSTB = 3;

  logic [1:0] rs_q;
  logic [NSTB-1:0] raw;
  logic [NSTB-1:0] stb_s;
  logic rd_prev_q, rd_prev_d;

  // reset: asserted asynchronously, released on clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign raw = {we_n, oe_n, ce_n};

  generate
    for (genvar g = 0; g < NSTB; g++) begin : g_stb
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
      end
      assign stb_s[g] = chain_q[STAGES-1];
    end
  endgenerate

  always_comb begin
    rd_act    = ~stb_s[0] & ~stb_s[1] & stb_s[2];
    rd_prev_d = rd_act;
    rd_start  = rd_act & ~rd_prev_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) rd_prev_q <= 1'b0;
    else         rd_prev_q <= rd_prev_d;
  end

  // R6: a read start lasts one cycle only
  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_start |=> !rd_start);
endmodule

// File: rtl/ee_toggle_ctl.sv
module ee_toggle_ctl (
  input  logic clk,
  input  logic rst_sn,
  input  logic busy,
  input  logic plt_run,
  input  logic rd_start,
  output logic tog_cur
);
  logic busy_q, plt_q;
  logic tog_q, tog_d;
  logic hold_q, hold_d;
  logic cyc_start, tog_base;

  always_comb begin
    cyc_start = (busy & ~busy_q) | (plt_run & ~plt_q) | (busy & ~plt_run & plt_q);
    tog_base  = cyc_start ? 1'b0 : tog_q;
    tog_d     = tog_q;
    hold_d    = hold_q;
    if (rd_start) begin
      hold_d = tog_base;
      tog_d  = ~tog_base;
    end else if (cyc_start) begin
      tog_d  = 1'b0;
    end
    tog_cur = rd_start ? tog_base : hold_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      plt_q  <= 1'b0;
      tog_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      busy_q <= busy;
      plt_q  <= plt_run;
      tog_q  <= tog_d;
      hold_q <= hold_d;
    end
  end

  // R7: a phase start with no read clears the toggle
  p_tog_clear_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && !busy_q && !rd_start) |=> !tog_q);

  // R6: value shown for the current read moves only at a read start
  p_hold_steady_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd_start |=> $stable(hold_q));
endmodule

// File: rtl/ee_dq_drive.sv
module ee_dq_drive
  import ee_rsp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          rd_act,
  input  logic          busy,
  input  logic          plt_run,
  input  logic [DW-1:0] last_data,
  input  logic          tog_cur,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam int LOW_W = DW - STAT_W;

  logic [DW-1:0] word_d, dq_d, dq_q;
  logic oe_d, oe_q, stat_d, stat_q;

  always_comb begin
    if (busy) word_d = {status_flags(last_data[DW-1], tog_cur, plt_run), {LOW_W{1'b0}}};
    else      word_d = arr_rdata;
    dq_d   = rd_act ? word_d : '0;
    oe_d   = rd_act;
    stat_d = rd_act & busy;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dq_q   <= '0;
      oe_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      dq_q   <= dq_d;
      oe_q   <= oe_d;
      stat_q <= stat_d;
    end
  end

  assign dq_out = dq_q;
  assign dq_oe  = oe_q;

  // R1: bus quiet when not driving
  p_quiet_bus_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !dq_oe |-> dq_out == '0);
  // R9: low status bits are zero
  p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (dq_oe && stat_q) |-> dq_out[LOW_W-1:0] == '0);
  // R3: polling bit opposes the written data
  p_poll_inv_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (dq_oe && stat_q) |-> dq_out[DW-1] != $past(last_data[DW-1]));
  // R6: toggle bit steady within one busy read
  p_tog_steady_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (dq_oe && stat_q && $past(dq_oe) && $past(stat_q)) |-> $stable(dq_out[DW-2]));
endmodule

// File: rtl/ee_status_responder.sv
module ee_status_responder #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          busy,
  input  logic          plt_run,
  input  logic [DW-1:0] last_data,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic rst_sn, rd_act, rd_start, tog_cur;

  ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rst_sn(rst_sn), .rd_act(rd_act), .rd_start(rd_start)
  );

  ee_toggle_ctl u_tog (
    .clk(clk), .rst_sn(rst_sn), .busy(busy), .plt_run(plt_run),
    .rd_start(rd_start), .tog_cur(tog_cur)
  );

  ee_dq_drive #(.DW(DW)) u_drv (
    .clk(clk), .rst_sn(rst_sn), .rd_act(rd_act), .busy(busy), .plt_run(plt_run),
    .last_data(last_data), .tog_cur(tog_cur), .arr_rdata(arr_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // R1: the drive enable follows only a decoded read
  p_oe_from_read_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    dq_oe |-> $past(rd_act));
endmodule

// File: tb/ee_status_responder_test.sv
module ee_status_responder_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, busy, plt_run;
  logic [DW-1:0] last_data, arr_rdata, dq_out;
  logic dq_oe;
  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic tog_model = 1'b0;
  int unsigned seed_sink;

  always #10 clk = ~clk;

  ee_status_responder #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .plt_run(plt_run), .last_data(last_data), .arr_rdata(arr_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] exp_word(logic b, logic p, logic [DW-1:0] ld,
                                             logic [DW-1:0] arr, logic t);
    if (b) return {~ld[DW-1], t, ~p, {(DW-3){1'b0}}};
    return arr;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // state: 0 idle, 1 loading, 2 programming
  task automatic set_state(int st);
    logic nb, np;
    nb = (st != 0);
    np = (st == 1);
    @(negedge clk);
    if ((nb && !busy) || (np && !plt_run) || (nb && !np && plt_run)) tog_model = 1'b0;
    busy = nb; plt_run = np;
    @(negedge clk);
  endtask

  task automatic do_read(int hold, logic [DW-1:0] ld, logic [DW-1:0] arr);
    logic [DW-1:0] e;
    @(negedge clk);
    last_data = ld; arr_rdata = arr;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 oe before third edge", {7'd0, dq_oe}, 8'd0);
    @(negedge clk);
    chk("R10 oe at third edge", {7'd0, dq_oe}, 8'd1);
    e = exp_word(busy, plt_run, ld, arr, tog_model);
    if (busy) begin
      chk("R3 polling bit", {7'd0, dq_out[7]}, {7'd0, e[7]});
      chk("R5 toggle bit", {7'd0, dq_out[6]}, {7'd0, e[6]});
      chk("R8 timer bit", {7'd0, dq_out[5]}, {7'd0, e[5]});
      chk("R9 low bits", {3'd0, dq_out[4:0]}, 8'd0);
    end else begin
      chk("R2 idle read", dq_out, e);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6 steady during read", dq_out, e);
    end
    tog_model = ~tog_model;
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 bus quiet after read", {dq_out[7:1], dq_oe}, 8'd0);
  endtask

  task automatic non_read(int kind);
    @(negedge clk);
    case (kind)
      0: begin ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; end
      1: begin ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; end
      default: begin ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; end
    endcase
    repeat (4) @(negedge clk);
    chk("R1 no drive on non-read", {dq_out[7:1], dq_oe}, 8'd0);
    chk("R1 data zero on non-read", dq_out, 8'd0);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    seed_sink = $urandom(32'h5eed_0b17);
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    busy = 1'b0; plt_run = 1'b0; last_data = '0; arr_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset state", {dq_out[7:1], dq_oe}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 after release", dq_out, 8'd0);
    chk("R11 oe after release", {7'd0, dq_oe}, 8'd0);

    // directed: idle read, then busy toggle sequence
    do_read(2, 8'h11, 8'hA5);
    set_state(1);
    do_read(0, 8'h80, 8'h00);               // R5 first read 0, R3 poll 0
    do_read(3, 8'h00, 8'hFF);               // toggle 1, poll 1
    non_read(2);                            // R1 must not advance toggle
    do_read(0, 8'h7F, 8'h00);
    set_state(2);                           // R7 programming start clears
    do_read(1, 8'hC3, 8'h3C);
    do_read(0, 8'hC3, 8'h3C);
    set_state(0);
    do_read(0, 8'hC3, 8'hC3);               // R4 true value after busy
    do_read(0, 8'h43, 8'h43);               // R4 bit 7 low
    set_state(2);                           // R7 busy rise clears
    do_read(0, 8'h01, 8'h02);

    for (int it = 0; it < 400; it++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 2)      set_state($urandom_range(0, 2));
      else if (r < 4) non_read($urandom_range(0, 2));
      else            do_read($urandom_range(0, 4), 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule